// File: doc/BRIEF.md
# UART FIFO Trigger-Flag Controller

This block sits between a processor's register port and the byte queues of a UART. It holds a 16-byte transmit queue and a 16-byte receive queue. Each queue has a trigger threshold that software picks from four codes. From these it raises a transmit-room flag and a receive-ready flag. Software can service the queues in bursts and does not need to handle one interrupt per byte.

Status bits are sticky. Software clears a bit only by reading it as 1 and then writing 0 to it. A level condition that still holds sets its flag again at once. The serial shifter, baud timing and parity logic sit outside the block and arrive as strobes. The block watches for a line break, which is a frame with all data bits and the stop bit at 0. During a break it stops storing received bytes but still records error status for every frame. It also exposes the raw line level so software can confirm the break.

Top module: `uart_fifo_flags`

## Requirements
- R1: A write to address 0 appends the low byte to the transmit queue. `tx_valid_o` is high while the queue holds data. `tx_data_o` shows the oldest byte, and `tx_pop_i` removes it, so bytes leave in write order.
- R2: Control register (address 2) bits [1:0] select the transmit threshold: code 0 gives 8, code 1 gives 4, code 2 gives 2 and code 3 gives 1. Status bit 0 sets whenever the transmit byte count is less than or equal to the threshold.
- R3: Control bits [3:2] select the receive threshold: code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 14. Status bit 1 sets whenever the receive byte count is greater than or equal to the threshold.
- R4: Status bits [5:0] clear only after a status read (address 1) returned the bit as 1 and a later status write carries 0 in that bit. Any status write ends that armed state. A write of 0 without such a read does nothing, and a write of 1 never clears a bit.
- R5: When a clear meets a set condition that still holds in the same cycle, the set wins and the bit stays 1.
- R6: A read of address 3 returns the transmit count in bits [14:8] and the receive count in bits [6:0]. All other bits read 0.
- R7: A received frame with stop bit 0 sets status bit 2 (framing error). A frame with `rx_par_err_i` high sets status bit 3 (parity error). A frame that is not a break frame is stored even if it has errors.
- R8: A frame with data 0 and stop bit 0 enters the break state, shown on status bit 6. That frame and every frame during the break are not stored, but bits 2 and 3 still update. The break state ends on the first cycle `rxd_i` is 1. Status bit 7 always shows the live `rxd_i` level.
- R9: A write to a full transmit queue and a byte arriving at a full receive queue are dropped. Each drop leaves the count at 16 and sets status bit 4 (transmit drop) or status bit 5 (receive drop).
- R10: During reset all status bits [6:0] and both counts read 0, and the control register reads 0.
- R11: A read of address 0 returns the oldest received byte in bits [7:0] and removes it, so bytes come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 2 | Register select: 0 data, 1 status, 2 control, 3 counts |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops receive data, arms status clears) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected address |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit queue not empty |
| tx_pop_i | input | 1 | Shifter takes the oldest transmit byte |
| rx_strobe_i | input | 1 | One received frame is complete |
| rx_data_i | input | 8 | Received data bits |
| rx_stop_i | input | 1 | Sampled stop bit level |
| rx_par_err_i | input | 1 | Parity check failed for this frame |
| rxd_i | input | 1 | Raw receive line level |

## Verification
The assertions assume single-cycle strobes. They also assume that a status read and a status write never occur in the same cycle, and that `rx_strobe_i` is high for only one cycle per frame. The bench meets this by driving every strobe for exactly one clock from its tasks, and it never overlaps register reads and writes. The bench steps through every threshold code for both queues and every fill level from empty to full plus one overflow byte. At each level it makes a read-then-clear attempt, so the result shows the threshold condition directly. During the break tests the bench holds `rxd_i` low for the whole break and raises it only to end the break.

// File: rtl/uff_pkg.sv
package uff_pkg;
  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CTRL = 2'd2,
    A_CNT  = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_TXE  = 0;
  localparam int unsigned ST_RXF  = 1;
  localparam int unsigned ST_FER  = 2;
  localparam int unsigned ST_PER  = 3;
  localparam int unsigned ST_TXOV = 4;
  localparam int unsigned ST_RXOV = 5;
  localparam int unsigned N_STICKY = 6;

  function automatic int unsigned tx_level(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned rx_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uff_byte_fifo.sv
module uff_byte_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             drop_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & ~empty;
  assign drop_o  = push_i & full;
  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> (cnt_q == CW'(DEPTH)));
  p_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/uff_sticky_bits.sv
module uff_sticky_bits #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q, armed_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr;
    // clear only when the bit was seen as 1 by a prior read; set wins
    assign clr = wr_i & armed_q[i] & ~wdata_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_q[i]     <= 1'b0;
        armed_q[i] <= 1'b0;
      end else begin
        q_q[i] <= set_i[i] | (q_q[i] & ~clr);
        if (rd_i)      armed_q[i] <= q_q[i];
        else if (wr_i) armed_q[i] <= 1'b0;
      end
    end

    p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_q[i]);
    p_clear_armed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(q_q[i]) |-> $past(wr_i && armed_q[i] && !wdata_i[i]));
  end

  assign q_o = q_q;
endmodule

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags
  import uff_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned CNT_FW = 7,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [15:0]   reg_rdata_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_pop_i,
  input  logic          rx_strobe_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_stop_i,
  input  logic          rx_par_err_i,
  input  logic          rxd_i
);
  logic [1:0]    tx_code_q, rx_code_q;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] rx_head;
  logic          tx_drop, rx_drop;
  logic          tx_push, rx_pop, rx_push;
  logic          brk_frame, brk_q;
  logic          st_rd, st_wr;
  logic [N_STICKY-1:0] sets, sticky;

  assign tx_push = reg_wr_i & (reg_addr_i == A_DATA);
  assign rx_pop  = reg_rd_i & (reg_addr_i == A_DATA);
  assign st_rd   = reg_rd_i & (reg_addr_i == A_STAT);
  assign st_wr   = reg_wr_i & (reg_addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_code_q <= '0;
      rx_code_q <= '0;
    end else if (reg_wr_i && reg_addr_i == A_CTRL) begin
      tx_code_q <= reg_wdata_i[1:0];
      rx_code_q <= reg_wdata_i[3:2];
    end
  end

  uff_byte_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .data_i(reg_wdata_i[DW-1:0]), .pop_i(tx_pop_i),
    .data_o(tx_data_o), .count_o(tx_cnt), .drop_o(tx_drop)
  );
  assign tx_valid_o = (tx_cnt != '0);

  // break gate: the receiver keeps flagging errors, storage is blocked
  assign brk_frame = rx_strobe_i & (rx_data_i == '0) & ~rx_stop_i;
  assign rx_push   = rx_strobe_i & ~brk_frame & ~brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        brk_q <= 1'b0;
    else if (brk_frame) brk_q <= 1'b1;
    else if (rxd_i)     brk_q <= 1'b0;
  end

  uff_byte_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .data_i(rx_data_i), .pop_i(rx_pop),
    .data_o(rx_head), .count_o(rx_cnt), .drop_o(rx_drop)
  );

  always_comb begin
    sets          = '0;
    sets[ST_TXE]  = tx_cnt <= CW'(tx_level(tx_code_q));
    sets[ST_RXF]  = rx_cnt >= CW'(rx_level(rx_code_q));
    sets[ST_FER]  = rx_strobe_i & ~rx_stop_i;
    sets[ST_PER]  = rx_strobe_i & rx_par_err_i;
    sets[ST_TXOV] = tx_drop;
    sets[ST_RXOV] = rx_drop;
  end

  uff_sticky_bits #(.N(N_STICKY)) u_flags (
    .clk_i, .rst_ni,
    .set_i(sets), .rd_i(st_rd), .wr_i(st_wr),
    .wdata_i(reg_wdata_i[N_STICKY-1:0]), .q_o(sticky)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DATA: reg_rdata_o[DW-1:0] = rx_head;
      A_STAT: reg_rdata_o[7:0]    = {rxd_i, brk_q, sticky};
      A_CTRL: reg_rdata_o[3:0]    = {rx_code_q, tx_code_q};
      default: begin
        reg_rdata_o[8 +: CNT_FW] = CNT_FW'(tx_cnt);
        reg_rdata_o[0 +: CNT_FW] = CNT_FW'(rx_cnt);
      end
    endcase
  end

  p_break_no_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((brk_q || brk_frame) && rx_strobe_i) |=> (rx_cnt <= $past(rx_cnt)));
  p_break_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxd_i && !rx_strobe_i) |=> !brk_q);
  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == A_CTRL) |=> $stable(tx_code_q));
endmodule

// File: tb/sim_uart_fifo_flags.sv
module sim_uart_fifo_flags;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  reg_addr_i = 2'd1;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, tx_pop_i = 1'b0;
  logic        rx_strobe_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_stop_i = 1'b1, rx_par_err_i = 1'b0, rxd_i = 1'b1;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  uart_fifo_flags u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk_i);
  endtask

  task automatic clear_bit(input int idx);
    logic [15:0] s;
    reg_rd(2'd1, s);
    reg_wr(2'd1, ~(8'h01 << idx));
    settle();
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic stop, input logic par);
    @(negedge clk_i);
    rx_strobe_i = 1'b1; rx_data_i = d; rx_stop_i = stop; rx_par_err_i = par;
    @(negedge clk_i);
    rx_strobe_i = 1'b0; rx_stop_i = 1'b1; rx_par_err_i = 1'b0;
    settle();
  endtask

  initial begin
    logic [15:0] s;
    // R10 reset state
    #1 chk("R10 status", reg_rdata_o, 16'h0080);
    reg_addr_i = 2'd3; #1 chk("R10 counts", reg_rdata_o, 16'h0000);
    reg_addr_i = 2'd2; #1 chk("R10 ctrl", reg_rdata_o, 16'h0000);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    reg_rd(2'd1, s);
    chk("R2 empty tx flag after reset", s[0], 1'b1);
    chk("R3 rx flag after reset", s[1], 1'b0);

    // transmit threshold sweep
    for (int c = 0; c < 4; c++) begin
      int lvl;
      lvl = (c == 0) ? 8 : (c == 1) ? 4 : (c == 2) ? 2 : 1;
      reg_wr(2'd2, 8'(c));
      for (int n = 0; n <= 16; n++) begin
        clear_bit(0);
        reg_rd(2'd1, s);
        chk((n <= lvl) ? "R5 tx flag re-set" : "R2 tx flag", s[0], (n <= lvl));
        reg_rd(2'd3, s);
        chk("R6 tx count", s[15:8], 8'(n));
        if (n < 16) reg_wr(2'd0, 8'(c * 32 + n + 1));
      end
      reg_wr(2'd0, 8'hEE);
      settle();
      reg_rd(2'd1, s);
      chk("R9 tx drop bit", s[4], 1'b1);
      reg_rd(2'd3, s);
      chk("R9 tx count held", s[15:8], 8'd16);
      // R4: write 0 without armed read has no effect
      reg_wr(2'd1, 8'hFF);
      reg_wr(2'd1, 8'hEF);
      settle();
      reg_rd(2'd1, s);
      chk("R4 unarmed clear ignored", s[4], 1'b1);
      clear_bit(4);
      reg_rd(2'd1, s);
      chk("R4 armed clear", s[4], 1'b0);
      for (int n = 0; n < 16; n++) begin
        @(negedge clk_i);
        chk("R1 tx valid", tx_valid_o, 1'b1);
        chk("R1 tx order", tx_data_o, 8'(c * 32 + n + 1));
        tx_pop_i = 1'b1;
        @(negedge clk_i);
        tx_pop_i = 1'b0;
      end
      chk("R1 tx drained", tx_valid_o, 1'b0);
    end

    // receive threshold sweep
    for (int c = 0; c < 4; c++) begin
      int lvl;
      lvl = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
      reg_wr(2'd2, 8'(c << 2));
      for (int n = 0; n <= 16; n++) begin
        clear_bit(1);
        reg_rd(2'd1, s);
        chk((n >= lvl) ? "R5 rx flag re-set" : "R3 rx flag", s[1], (n >= lvl));
        reg_rd(2'd3, s);
        chk("R6 rx count", {s[15:7], s[6:0]}, 16'(n));
        if (n < 16) rx_frame(8'(8'h40 + c * 16 + n), 1'b1, 1'b0);
      end
      rx_frame(8'h99, 1'b1, 1'b0);
      reg_rd(2'd1, s);
      chk("R9 rx drop bit", s[5], 1'b1);
      reg_rd(2'd3, s);
      chk("R9 rx count held", s[6:0], 7'd16);
      for (int n = 0; n < 16; n++) begin
        reg_rd(2'd0, s);
        chk("R11 rx order", s, 16'(8'h40 + c * 16 + n));
      end
      reg_rd(2'd3, s);
      chk("R11 rx drained", s, 16'h0000);
      clear_bit(5);
      reg_rd(2'd1, s);
      chk("R4 rx drop cleared", s[5], 1'b0);
    end

    // framing and parity
    reg_wr(2'd2, 8'h00);
    rx_frame(8'h12, 1'b0, 1'b0);
    reg_rd(2'd1, s);
    chk("R7 framing bit", s[3:2], 2'b01);
    chk("R7 no break", s[6], 1'b0);
    rx_frame(8'h34, 1'b1, 1'b1);
    reg_rd(2'd1, s);
    chk("R7 parity bit", s[3], 1'b1);
    reg_rd(2'd3, s);
    chk("R7 error frames stored", s[6:0], 7'd2);
    reg_rd(2'd0, s); chk("R7 byte 1", s, 16'h0012);
    reg_rd(2'd0, s); chk("R7 byte 2", s, 16'h0034);
    clear_bit(2); clear_bit(3);
    reg_rd(2'd1, s);
    chk("R4 error bits cleared", s[3:2], 2'b00);

    // break handling
    @(negedge clk_i); rxd_i = 1'b0;
    rx_frame(8'h00, 1'b0, 1'b1);
    reg_rd(2'd1, s);
    chk("R8 break bit", s[6], 1'b1);
    chk("R8 line level low", s[7], 1'b0);
    chk("R8 errors during break", s[3:2], 2'b11);
    reg_rd(2'd3, s);
    chk("R8 break frame not stored", s[6:0], 7'd0);
    clear_bit(2);
    reg_rd(2'd1, s);
    chk("R8 framing cleared in break", s[2], 1'b0);
    rx_frame(8'h55, 1'b0, 1'b0);
    reg_rd(2'd1, s);
    chk("R8 receiver still flags", s[2], 1'b1);
    rx_frame(8'h56, 1'b1, 1'b0);
    reg_rd(2'd3, s);
    chk("R8 nothing stored in break", s[6:0], 7'd0);
    reg_rd(2'd1, s);
    chk("R8 break held", s[6], 1'b1);
    @(negedge clk_i); rxd_i = 1'b1;
    settle();
    reg_rd(2'd1, s);
    chk("R8 break left", s[7:6], 2'b10);
    rx_frame(8'h77, 1'b1, 1'b0);
    reg_rd(2'd0, s);
    chk("R8 storage resumes", s, 16'h0077);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule